// File: doc/BRIEF.md
# Host Command Byte Port

This block is a slave port on an 8-bit asynchronous parallel bus. An external host uses it to hand short command packets to a local CPU. The host side has an active-low chip select, active-low write and read strobes, one address line and an 8-bit data bus. The data bus is split into separate input, output and output-enable signals. With the address line high, a host write pushes one byte into a 16-entry command buffer. A host read with the address line high returns a host status byte.

The host status byte carries a busy bit in bit 7 and a 7-bit software status field in bits 6:0. The first byte the host writes raises the busy flag. The host polls the busy bit and sends a new packet only while it is clear. The CPU reads the bytes in arrival order and checks the empty flag before each read. It may write a status value for the host, and it clears busy when it has finished processing. The busy flag can raise an interrupt, gated by two enables.

The host control lines pass through clock-domain synchronizers. The data bus is sampled a programmable 0 to 7 clock cycles after the write strobe is seen, so a slow host has time to settle the data.

Top module: `hostcmd_port`

## Requirements
- R1: After reset, empty=1, busy=0, overrun=0 and irq=0, and a host status read returns 0x00.
- R2: With h_cs_n=0, h_rd_n=0 and h_addr=1 (after synchronization), h_doe=1 and h_dout = {busy, software status[6:0]}, with busy in bit 7.
- R3: A host write is accepted once per falling edge of h_wr_n while h_cs_n=0 and h_addr=1. Holding the strobe low stores one byte only, and empty goes to 0.
- R4: h_din is captured on the (3+D)th rising clock edge after h_wr_n and h_cs_n are driven low, where D is the 3-bit wr_dly value.
- R5: An accepted host byte sets busy, and the host status bit 7 reads 1 until busy is cleared.
- R6: A pulse on cpu_clr_busy clears busy, clears host status bit 7 and clears the overrun flag.
- R7: A pulse on cpu_stat_we loads cpu_stat_wdata into status bits 6:0, and a later host status read returns those bits.
- R8: irq is 1 exactly when busy=1, irq_busy_en=1 and irq_glob_en=1.
- R9: A cpu_rd pulse returns bytes in arrival order on cpu_rdata, valid from the clock edge that samples the pulse. empty returns to 1 after the last stored byte is read.
- R10: The buffer holds 16 bytes. A host write while it is full is dropped, and overrun is set and stays set until cpu_clr_busy.
- R11: A cpu_rd while empty=1 leaves cpu_rdata at the last byte read and does not advance the read position, so the next host byte is the next byte read.
- R12: Host writes with h_addr=0 are ignored (empty and busy unchanged), and host reads with h_addr=0 leave h_doe=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_cs_n | input | 1 | Host chip select, active low |
| h_wr_n | input | 1 | Host write strobe, active low |
| h_rd_n | input | 1 | Host read strobe, active low |
| h_addr | input | 1 | Host address line; 1 selects the command/status register |
| h_din | input | 8 | Host write data |
| h_dout | output | 8 | Host read data |
| h_doe | output | 1 | Host data bus output enable |
| cpu_rd | input | 1 | CPU read pulse, pops one byte |
| cpu_rdata | output | 8 | Last byte popped by the CPU |
| cpu_clr_busy | input | 1 | CPU pulse clearing busy and overrun |
| cpu_stat_we | input | 1 | CPU write pulse for the software status field |
| cpu_stat_wdata | input | 7 | Software status value |
| irq_busy_en | input | 1 | Busy interrupt enable |
| irq_glob_en | input | 1 | Global interrupt enable for this port |
| wr_dly | input | 3 | Write sampling delay in clock cycles |
| busy | output | 1 | Busy flag |
| empty | output | 1 | No unread byte in the buffer |
| overrun | output | 1 | Sticky flag: a host byte was dropped |
| irq | output | 1 | Interrupt request |

## Verification
The bench moves the host data bus in the middle of a write strobe at delay settings on either side of the change. A sampler with a delay that is off by one cycle, or that ignores wr_dly, captures the wrong byte. It holds the write strobe low for many cycles to catch a level-triggered write, which would fill the buffer with copies of one byte. It fills all 16 entries and then writes once more. A design with a wrong depth either drops a valid byte or overwrites an unread one. A missing overrun flag goes unnoticed by the CPU. It also pops an empty buffer and then writes a new byte, which exposes a read pointer that wrapped past the write pointer and returned stale data.

// File: rtl/hcp_pkg.sv
package hcp_pkg;
   typedef enum logic [0:0] {
      SAMP_IDLE = 1'b0,
      SAMP_WAIT = 1'b1
   } samp_state_t;

   localparam int unsigned HCP_CTRL_W = 4;
endpackage

// File: rtl/hcp_sync.sv
module hcp_sync #(
   parameter int unsigned W        = 4,
   parameter int unsigned STAGES   = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_chk_stages
      $error("hcp_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= RST_VAL;
         end else if (s == 0) begin
            chain[s] <= d;
         end else begin
            chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hcp_wr_sampler.sv
module hcp_wr_sampler
   import hcp_pkg::*;
#(
   parameter int unsigned DW    = 8,
   parameter int unsigned DLY_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n_s,
   input  logic             wr_n_s,
   input  logic             addr_s,
   input  logic [DLY_W-1:0] dly,
   input  logic [DW-1:0]    din,
   output logic             push,
   output logic [DW-1:0]    pdata
);
   if (DLY_W < 1) begin : g_chk_dly
      $error("hcp_wr_sampler: DLY_W must be at least 1");
   end

   logic             wr_q;
   logic             fall;
   samp_state_t      st;
   logic [DLY_W-1:0] cnt;

   assign fall = wr_q & ~wr_n_s & ~cs_n_s & addr_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= 1'b1;
         st   <= SAMP_IDLE;
         cnt  <= '0;
      end else begin
         wr_q <= wr_n_s;
         case (st)
            SAMP_IDLE: begin
               if (fall && (dly != '0)) begin
                  st  <= SAMP_WAIT;
                  cnt <= dly;
               end
            end
            default: begin
               cnt <= cnt - 1'b1;
               if (cnt == DLY_W'(1)) st <= SAMP_IDLE;
            end
         endcase
      end
   end

   assign push  = ((st == SAMP_IDLE) && fall && (dly == '0)) ||
                  ((st == SAMP_WAIT) && (cnt == DLY_W'(1)));
   assign pdata = din;
endmodule

// File: rtl/hcp_fifo.sv
module hcp_fifo #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [DW-1:0]              wdata,
   input  logic                       pop,
   output logic [DW-1:0]              rdata,
   output logic                       empty,
   output logic                       full,
   output logic [$clog2(DEPTH):0]     level
);
   localparam int unsigned AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_chk_depth
      $error("hcp_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW:0]   wp, rp;
   logic          do_push, do_pop;

   assign empty   = (wp == rp);
   assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign level   = wp - rp;
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;

   always_ff @(posedge clk) begin
      if (do_push) mem[wp[AW-1:0]] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         rdata <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop) begin
            rdata <= mem[rp[AW-1:0]];
            rp    <= rp + 1'b1;
         end
      end
   end
endmodule

// File: rtl/hostcmd_port.sv
module hostcmd_port
   import hcp_pkg::*;
#(
   parameter int unsigned DW          = 8,
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned DLY_W       = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             h_cs_n,
   input  logic             h_wr_n,
   input  logic             h_rd_n,
   input  logic             h_addr,
   input  logic [DW-1:0]    h_din,
   output logic [DW-1:0]    h_dout,
   output logic             h_doe,
   input  logic             cpu_rd,
   output logic [DW-1:0]    cpu_rdata,
   input  logic             cpu_clr_busy,
   input  logic             cpu_stat_we,
   input  logic [DW-2:0]    cpu_stat_wdata,
   input  logic             irq_busy_en,
   input  logic             irq_glob_en,
   input  logic [DLY_W-1:0] wr_dly,
   output logic             busy,
   output logic             empty,
   output logic             overrun,
   output logic             irq
);
   localparam int unsigned LW = $clog2(DEPTH) + 1;

   if (DW < 2) begin : g_chk_dw
      $error("hostcmd_port: DW must be at least 2");
   end

   logic [HCP_CTRL_W-1:0] ctrl_s;
   logic                  cs_n_s, wr_n_s, rd_n_s, addr_s;
   logic                  push, full, push_ok;
   logic [DW-1:0]         pdata;
   logic [LW-1:0]         level;
   logic [DW-2:0]         stat_q;
   logic                  busy_q, ovr_q;

   hcp_sync #(
      .W       (HCP_CTRL_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (4'b1110)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({h_cs_n, h_wr_n, h_rd_n, h_addr}),
      .q     (ctrl_s)
   );

   assign {cs_n_s, wr_n_s, rd_n_s, addr_s} = ctrl_s;

   hcp_wr_sampler #(
      .DW    (DW),
      .DLY_W (DLY_W)
   ) u_samp (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_n_s (cs_n_s),
      .wr_n_s (wr_n_s),
      .addr_s (addr_s),
      .dly    (wr_dly),
      .din    (h_din),
      .push   (push),
      .pdata  (pdata)
   );

   hcp_fifo #(
      .DW    (DW),
      .DEPTH (DEPTH)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .wdata (pdata),
      .pop   (cpu_rd),
      .rdata (cpu_rdata),
      .empty (empty),
      .full  (full),
      .level (level)
   );

   assign push_ok = push & ~full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ovr_q  <= 1'b0;
         stat_q <= '0;
      end else begin
         if (push_ok)           busy_q <= 1'b1;
         else if (cpu_clr_busy) busy_q <= 1'b0;

         if (push && full)      ovr_q <= 1'b1;
         else if (cpu_clr_busy) ovr_q <= 1'b0;

         if (cpu_stat_we) stat_q <= cpu_stat_wdata;
      end
   end

   assign h_doe   = ~cs_n_s & ~rd_n_s & addr_s;
   assign h_dout  = h_doe ? {busy_q, stat_q} : '0;
   assign busy    = busy_q;
   assign overrun = ovr_q;
   assign irq     = busy_q & irq_busy_en & irq_glob_en;
endmodule

// File: rtl/hostcmd_port_chk.sv
module hostcmd_port_chk #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned LW    = $clog2(DEPTH) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          h_doe,
   input logic [DW-1:0] h_dout,
   input logic          cpu_rd,
   input logic [DW-1:0] cpu_rdata,
   input logic          cpu_clr_busy,
   input logic          busy,
   input logic          empty,
   input logic          overrun,
   input logic          push,
   input logic [LW-1:0] level
);
   p_busy_implies_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !empty);

   p_clear_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clr_busy && !push |=> !busy);

   p_host_busy_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      h_doe |-> (h_dout[DW-1] == busy));

   p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      overrun && !cpu_clr_busy |=> overrun);

   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));

   p_empty_read_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rd && empty |=> $stable(cpu_rdata));
endmodule

bind hostcmd_port hostcmd_port_chk #(
   .DW    (DW),
   .DEPTH (DEPTH)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .h_doe        (h_doe),
   .h_dout       (h_dout),
   .cpu_rd       (cpu_rd),
   .cpu_rdata    (cpu_rdata),
   .cpu_clr_busy (cpu_clr_busy),
   .busy         (busy),
   .empty        (empty),
   .overrun      (overrun),
   .push         (push),
   .level        (level)
);

// File: tb/hostcmd_port_tb.sv
module hostcmd_port_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       h_cs_n = 1'b1, h_wr_n = 1'b1, h_rd_n = 1'b1, h_addr = 1'b0;
   logic [7:0] h_din = '0;
   logic [7:0] h_dout;
   logic       h_doe;
   logic       cpu_rd = 1'b0;
   logic [7:0] cpu_rdata;
   logic       cpu_clr_busy = 1'b0, cpu_stat_we = 1'b0;
   logic [6:0] cpu_stat_wdata = '0;
   logic       irq_busy_en = 1'b0, irq_glob_en = 1'b0;
   logic [2:0] wr_dly = '0;
   logic       busy, empty, overrun, irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   hostcmd_port u_dut (
      .clk(clk), .rst_n(rst_n), .h_cs_n(h_cs_n), .h_wr_n(h_wr_n), .h_rd_n(h_rd_n),
      .h_addr(h_addr), .h_din(h_din), .h_dout(h_dout), .h_doe(h_doe),
      .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cpu_clr_busy(cpu_clr_busy),
      .cpu_stat_we(cpu_stat_we), .cpu_stat_wdata(cpu_stat_wdata),
      .irq_busy_en(irq_busy_en), .irq_glob_en(irq_glob_en), .wr_dly(wr_dly),
      .busy(busy), .empty(empty), .overrun(overrun), .irq(irq)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [7:0] d, input logic a);
      @(negedge clk);
      h_cs_n = 1'b0; h_addr = a; h_din = d; h_wr_n = 1'b0;
      repeat (14) @(posedge clk);
      @(negedge clk);
      h_wr_n = 1'b1; h_cs_n = 1'b1;
      repeat (4) @(posedge clk);
   endtask

   task automatic host_read(input logic a, output logic oe, output logic [7:0] d);
      @(negedge clk);
      h_cs_n = 1'b0; h_addr = a; h_rd_n = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      oe = h_doe; d = h_dout;
      h_rd_n = 1'b1; h_cs_n = 1'b1;
      repeat (4) @(posedge clk);
   endtask

   task automatic cpu_read(output logic [7:0] d);
      @(negedge clk); cpu_rd = 1'b1;
      @(negedge clk); cpu_rd = 1'b0;
      d = cpu_rdata;
   endtask

   task automatic cpu_clear();
      @(negedge clk); cpu_clr_busy = 1'b1;
      @(negedge clk); cpu_clr_busy = 1'b0;
   endtask

   task automatic drain();
      logic [7:0] d;
      while (!empty) cpu_read(d);
      cpu_clear();
   endtask

   task automatic t_reset();
      logic oe; logic [7:0] d;
      check("R1 empty", empty, 1);
      check("R1 busy", busy, 0);
      check("R1 overrun", overrun, 0);
      check("R1 irq", irq, 0);
      host_read(1'b1, oe, d);
      check("R1 status", d, 8'h00);
      check("R2 doe", oe, 1);
   endtask

   task automatic t_status();
      logic oe; logic [7:0] d;
      @(negedge clk); cpu_stat_we = 1'b1; cpu_stat_wdata = 7'h55;
      @(negedge clk); cpu_stat_we = 1'b0;
      host_read(1'b1, oe, d);
      check("R7 status field", d, 8'h55);
      host_write(8'hA1, 1'b1);
      host_read(1'b1, oe, d);
      check("R5 host busy bit", d, 8'hD5);
      check("R5 busy", busy, 1);
      check("R3 not empty", empty, 0);
      cpu_read(d);
      check("R9 data", d, 8'hA1);
      check("R3 single byte per strobe", empty, 1);
      cpu_clear();
      host_read(1'b1, oe, d);
      check("R6 host busy cleared", d, 8'h55);
      check("R6 busy", busy, 0);
   endtask

   task automatic delay_case(input logic [2:0] dv, input logic [7:0] exp);
      logic [7:0] d;
      wr_dly = dv;
      @(negedge clk);
      h_cs_n = 1'b0; h_addr = 1'b1; h_din = 8'h3C; h_wr_n = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk); h_din = 8'hC3;
      repeat (12) @(posedge clk);
      @(negedge clk); h_wr_n = 1'b1; h_cs_n = 1'b1;
      repeat (4) @(posedge clk);
      cpu_read(d);
      check($sformatf("R4 delay %0d", dv), d, exp);
      drain();
   endtask

   task automatic t_delay();
      delay_case(3'd0, 8'h3C);
      delay_case(3'd1, 8'h3C);
      delay_case(3'd2, 8'hC3);
      delay_case(3'd7, 8'hC3);
      wr_dly = 3'd0;
   endtask

   task automatic t_fill();
      logic [7:0] d;
      for (int i = 0; i < 16; i++) host_write(8'h10 + 8'(i), 1'b1);
      check("R10 no overrun at 16", overrun, 0);
      host_write(8'hEE, 1'b1);
      check("R10 overrun set", overrun, 1);
      for (int i = 0; i < 16; i++) begin
         cpu_read(d);
         check($sformatf("R9 order %0d", i), d, 8'h10 + i);
      end
      check("R9 empty after last", empty, 1);
      check("R10 overrun sticky", overrun, 1);
      cpu_read(d);
      check("R11 empty read holds", d, 8'h1F);
      host_write(8'h77, 1'b1);
      cpu_read(d);
      check("R11 pointer not advanced", d, 8'h77);
      cpu_clear();
      check("R6 overrun cleared", overrun, 0);
   endtask

   task automatic t_addr_low();
      logic oe; logic [7:0] d;
      host_write(8'h99, 1'b0);
      check("R12 write ignored empty", empty, 1);
      check("R12 write ignored busy", busy, 0);
      host_read(1'b0, oe, d);
      check("R12 no drive", oe, 0);
   endtask

   task automatic t_irq();
      irq_busy_en = 1'b1; irq_glob_en = 1'b0;
      host_write(8'h42, 1'b1);
      check("R8 global off", irq, 0);
      @(negedge clk); irq_glob_en = 1'b1;
      @(negedge clk);
      check("R8 both on", irq, 1);
      irq_busy_en = 1'b0;
      @(negedge clk);
      check("R8 busy en off", irq, 0);
      irq_busy_en = 1'b1;
      drain();
      check("R8 cleared with busy", irq, 0);
      irq_busy_en = 1'b0; irq_glob_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_status();
      t_delay();
      t_fill();
      t_addr_low();
      t_irq();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule